// File: doc/BRIEF.md
# GPIO Port with Pullup and Analog Override

An eight-pin general-purpose I/O port controller that is reached through a small synchronous register bus. It holds three registers: a data latch, a direction mask and a pullup enable mask. For each pin it drives an output value, an output enable and a pullup enable. A pullup is connected only while its pin is an input. Pin levels reach the read path through a two-flop synchronizer.

An external analog channel select can take one pin away from digital control. That pin's output driver and pullup are then switched off, whatever the registers hold, so the pin can serve an analog input path. The data latch has no reset, so its contents survive a reset. The two mask registers clear on reset, which makes every pin an undriven input with no pullup.

Top module: `gpio_port`

## Requirements
- R1: Register addresses on the 2-bit `bus_addr` are 0 = data latch, 1 = direction (bit 1 = output), 2 = pullup enable (bit 1 = pullup requested) and 3 = unused. A write with `bus_we` high takes effect at the rising edge. A write to address 3 changes nothing. `bus_rdata` follows the current address combinationally, and address 3 reads 0x00.
- R2: After reset, the direction register and the pullup enable register both read 0x00, and `pin_oe` and `pin_pu` are both 0x00.
- R3: `pin_pu[i]` is 1 only when pullup bit i is 1, direction bit i is 0 and pin i is not analog-selected.
- R4: Reset leaves the data latch unchanged. Its value before the first write is undefined.
- R5: `pin_out` equals the data latch. `pin_oe[i]` equals direction bit i unless pin i is analog-selected.
- R6: When `ana_en` is 1, the pin numbered `ana_sel` (0..7) has `pin_oe` and `pin_pu` at 0, and its bit reads 0 at data address 0.
- R7: When `ana_en` is 0, no pin is overridden.
- R8: At data address 0, a non-analog bit reads the latch bit when the pin is an output. When the pin is an input, the bit reads the pin level sampled through two flops, so a change on `pin_in` shows after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pin_in | input | 8 | Pin levels from the pads |
| ana_sel | input | 3 | Analog channel number |
| ana_en | input | 1 | Analog override enable |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |
| pin_pu | output | 8 | Pullup enable per pin |

## Verification
The assertions check on every cycle that no pin ever has its pullup and its driver on together. They also check that the analog-selected pin is released from both and that the outputs follow the direction bits when no override is active. In addition, they confirm that a register write lands on the following edge.

Only the bench scenarios can show the following:
- the data latch keeping its value through a reset;
- the two-edge latency of the input synchronizer;
- the analog pin reading zero;
- ignored writes to the unused address.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8,
  parameter int AW = 2,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  input  logic [SW-1:0] ana_sel,
  input  logic          ana_en,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_pu
);
  localparam logic [AW-1:0] A_DAT = AW'(0);
  localparam logic [AW-1:0] A_DIR = AW'(1);
  localparam logic [AW-1:0] A_PUE = AW'(2);

  logic [W-1:0] lat_q, dir_q, pue_q, s1_q, s2_q;
  logic [W-1:0] ana_mask, in_view;

  assign ana_mask = ana_en ? (W'(1) << ana_sel) : '0;

  always_ff @(posedge clk)
    if (bus_we && bus_addr == A_DAT) lat_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      pue_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      if (bus_we && bus_addr == A_DIR) dir_q <= bus_wdata;
      if (bus_we && bus_addr == A_PUE) pue_q <= bus_wdata;
    end

  assign pin_out = lat_q;
  assign pin_oe  = dir_q & ~ana_mask;
  assign pin_pu  = pue_q & ~dir_q & ~ana_mask;
  assign in_view = ((dir_q & lat_q) | (~dir_q & s2_q)) & ~ana_mask;

  always_comb begin
    case (bus_addr)
      A_DAT:   bus_rdata = in_view;
      A_DIR:   bus_rdata = dir_q;
      A_PUE:   bus_rdata = pue_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module gpio_port_chk #(
  parameter int W = 8,
  parameter int AW = 2,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [W-1:0]  bus_wdata,
  input logic [SW-1:0] ana_sel,
  input logic          ana_en,
  input logic [W-1:0]  pin_oe,
  input logic [W-1:0]  pin_pu,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  pue_q,
  input logic [W-1:0]  lat_q
);
  assert_pu_off_when_driving_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);
  assert_pu_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & ~pue_q) == '0);
  assert_analog_pin_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ana_en |-> (!pin_oe[ana_sel] && !pin_pu[ana_sel]));
  assert_no_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_en |-> (pin_oe == dir_q));
  assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(1)) |=> dir_q == $past(bus_wdata));
  assert_pue_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(2)) |=> pue_q == $past(bus_wdata));
  assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(0)) |=> lat_q == $past(bus_wdata));
endmodule

bind gpio_port gpio_port_chk #(.W(W), .AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .ana_sel(ana_sel), .ana_en(ana_en),
  .pin_oe(pin_oe), .pin_pu(pin_pu), .dir_q(dir_q), .pue_q(pue_q), .lat_q(lat_q)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 0;
  logic [2:0] ana_sel = 0;
  logic       ana_en = 0;
  logic [7:0] pin_out, pin_oe, pin_pu;

  int checks = 0, fails = 0;
  logic [7:0] m_lat, m_dir, m_pue;

  always #2 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .ana_sel(ana_sel), .ana_en(ana_en), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  function automatic logic [7:0] amask();
    return ana_en ? (8'd1 << ana_sel) : 8'd0;
  endfunction

  function automatic logic [7:0] exp_oe();
    return m_dir & ~amask();
  endfunction

  function automatic logic [7:0] exp_pu();
    return m_pue & ~m_dir & ~amask();
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    logic [7:0] r;
    case (a)
      2'd0: begin
        for (int i = 0; i < 8; i++)
          r[i] = amask() ? (amask() & (8'd1 << i)) == 0 && (m_dir[i] ? m_lat[i] : pin_in[i])
                         : (m_dir[i] ? m_lat[i] : pin_in[i]);
      end
      2'd1: r = m_dir;
      2'd2: r = m_pue;
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    case (a)
      2'd0: m_lat = d;
      2'd1: m_dir = d;
      2'd2: m_pue = d;
      default: ;
    endcase
  endtask

  task automatic rd(input string tag, input logic [1:0] a);
    @(negedge clk);
    bus_addr = a;
    #1 chk(tag, bus_rdata, exp_rd(a));
  endtask

  task automatic pins_check(input string tag);
    #1;
    chk({tag, " R5 oe"}, pin_oe, exp_oe());
    chk({tag, " R3 pu"}, pin_pu, exp_pu());
    chk({tag, " R5 out"}, pin_out, m_lat);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_dir = 0; m_pue = 0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    do_reset();
    rd("R2 dir after reset", 2'd1);
    rd("R2 pue after reset", 2'd2);
    #1;
    chk("R2 oe after reset", pin_oe, 8'h00);
    chk("R2 pu after reset", pin_pu, 8'h00);

    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'hFF);
    pins_check("directed");
    wr(2'd3, 8'h3C);
    rd("R1 unused addr reads zero", 2'd3);
    rd("R1 dir kept after addr3 write", 2'd1);
    rd("R1 pue kept after addr3 write", 2'd2);
    rd("R1 latch kept after addr3 write", 2'd0);

    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hF0;
    @(negedge clk); bus_addr = 0;
    #1 chk("R8 sync after one edge", bus_rdata, 8'h05);
    @(negedge clk);
    #1 chk("R8 sync after two edges", bus_rdata, 8'hF5);

    ana_en = 1; ana_sel = 3'd2;
    pins_check("R6 analog output pin");
    rd("R6 analog pin reads zero", 2'd0);
    ana_sel = 3'd6;
    pins_check("R6 analog input pin");
    chk("R6 pullup off on analog pin", pin_pu & 8'h40, 8'h00);
    rd("R6 analog input pin reads zero", 2'd0);
    ana_en = 0;
    pins_check("R7 no override");
    rd("R7 full readback", 2'd0);

    do_reset();
    wr(2'd1, 8'hFF);
    rd("R4 latch survives reset", 2'd0);
    pins_check("R4 after reset");

    for (int n = 0; n < 300; n++) begin
      wr(2'($urandom_range(0, 3)), 8'($urandom));
      pin_in  = 8'($urandom);
      ana_en  = 1'($urandom);
      ana_sel = 3'($urandom);
      repeat (3) @(negedge clk);
      pins_check("random");
      for (int a = 0; a < 4; a++) rd("random R1 R6 R8 readback", 2'(a));
      if (n == 150) begin
        do_reset();
        repeat (3) @(negedge clk);
        rd("R2 dir after mid reset", 2'd1);
        rd("R2 pue after mid reset", 2'd2);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule